// File: doc/BRIEF.md
# Vectored Interrupt Entry Controller

This block works next to the program counter of a small 8-bit microcontroller core. It decides when instruction fetch must jump to a fixed service address. There are four maskable sources, in fixed order: an external pin, a timer overflow, an analog-to-digital end-of-conversion, and a two-wire bus event. The bus event is a slave address match or a finished one-byte transfer. Each source has its own enable bit, and a global enable sits above all four. The core raises a one-cycle request pulse for a source. That pulse sets a sticky pending flag, and the flag stays set until the source is serviced.

The block also holds the return-address stack. Subroutine calls and interrupt entries share this stack. It stores program-counter values only and software cannot reach it. An interrupt is never taken while the stack is full. A call made while the stack is full still goes ahead and replaces the oldest entry. The core reports its call, return and return-from-interrupt strobes and the current program counter. It receives back a vector-load strobe with its target address, push and pop indications, and the return address to reload.

Top module: `irq_entry_ctrl`

## Requirements
- R1: In the first cycle after reset is released, `vec_load_o` is 1 with `vec_addr_o` = 12'h000, `gie_o` is 0 and `stk_full_o` is 0. `vec_load_o` falls in the next cycle.
- R2: The vector for source index s is (s+1)*4. Source 0 (external) goes to 12'h004, source 1 (timer) to 12'h008, source 2 (converter) to 12'h00C and source 3 (bus) to 12'h010.
- R3: An entry happens only when four conditions hold: the source is pending, its `irq_en_i` bit is 1, the global enable is 1 and the stack is not full. A blocked request stays pending and is taken as soon as all four conditions hold.
- R4: When several enabled requests are pending, the source with the lowest vector address is taken first. The others stay pending.
- R5: A request pulse in cycle n gives `vec_load_o` in cycle n+1, and only for that cycle. The entry asserts `stk_push_o`, stores `pc_i`, clears that source's pending flag and clears the global enable.
- R6: `call_i` pushes `pc_i`. `ret_i` and `reti_i` pop, and `ret_addr_o` shows the most recently pushed value, so the order is last in, first out. A pop on an empty stack gives `stk_pop_o` = 0.
- R7: `reti_i` sets the global enable for the next cycle. `ret_i` leaves the global enable unchanged.
- R8: `stk_full_o` is 1 when the stack holds `STK_DEPTH` entries. A call made while full overwrites the oldest entry, and the count stays at `STK_DEPTH`.
- R9: No entry is taken in a cycle that carries `call_i`, `ret_i` or `reti_i`. If a return strobe and `call_i` come in the same cycle, only the pop is performed.
- R10: `gie_set_i` sets the global enable and `gie_clr_i` clears it. When both come in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req_i | input | 4 | Request pulses; bit 0 external, 1 timer, 2 converter, 3 bus |
| irq_en_i | input | 4 | Per-source enable bits, same order as the requests |
| gie_set_i | input | 1 | Strobe that sets the global enable |
| gie_clr_i | input | 1 | Strobe that clears the global enable |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| reti_i | input | 1 | Interrupt return strobe |
| pc_i | input | PC_W | Program counter value to store on a push |
| vec_load_o | output | 1 | Load `vec_addr_o` into the program counter |
| vec_addr_o | output | PC_W | Reset or service address |
| stk_push_o | output | 1 | A push happens this cycle |
| stk_pop_o | output | 1 | A pop happens this cycle |
| ret_addr_o | output | PC_W | Entry on top of the stack |
| stk_full_o | output | 1 | The stack holds STK_DEPTH entries |
| gie_o | output | 1 | Current global enable |

## Verification
The bench uses the defaults: a 12-bit program counter, eight stack levels and a vector step of four. With these values the address map can be compared directly with the fixed service locations. Nine calls are enough to fill the stack and push it one past full. The bench then unwinds the stack completely, which shows that the oldest entry was lost. While the stack is full, a held bus request shows that entry is blocked, and a single return frees a slot and lets the entry go ahead.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NUM_SRC = 4;
    typedef enum logic [1:0] {
        SRC_EXT = 2'd0,
        SRC_TMR = 2'd1,
        SRC_ADC = 2'd2,
        SRC_BUS = 2'd3
    } src_e;

    function automatic int unsigned vector_of(input int unsigned idx, input int unsigned step);
        return (idx + 1) * step;
    endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } pend_st_t;

    pend_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pend = (s_q.pend & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;

    // R5: a cleared flag with no fresh request is gone next cycle
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));
    // R3: a flag is held until it is cleared
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
    parameter int N = 4
) (
    input  logic [N-1:0]         cand_i,
    output logic [N-1:0]         grant_o,
    output logic [$clog2(N)-1:0] idx_o,
    output logic                 any_o
);
    localparam int IW = $clog2(N);

    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                grant_o = '0;
                grant_o[i] = 1'b1;
                idx_o   = IW'(i);
                any_o   = 1'b1;
            end
        end
    end

    // R4: at most one winner, and only from the candidates
    always_comb begin
        p_grant_onehot_r4: assert ($onehot0(grant_o) && ((grant_o & ~cand_i) == '0));
    end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
    parameter int PC_W  = 12,
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] data_i,
    output logic [PC_W-1:0] top_o,
    output logic            full_o,
    output logic            empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] mem;
        logic [PTR_W-1:0]           wp;
        logic [CNT_W-1:0]           cnt;
    } stk_st_t;

    stk_st_t s_d, s_q;
    logic [PTR_W-1:0] rd_idx;

    assign rd_idx  = s_q.wp - PTR_W'(1);
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CNT_W'(DEPTH));
    assign top_o   = s_q.mem[rd_idx];

    always_comb begin
        s_d = s_q;
        if (pop_i && !empty_o) begin
            s_d.wp  = rd_idx;
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end else if (push_i) begin
            s_d.mem[s_q.wp] = data_i;
            s_d.wp          = s_q.wp + PTR_W'(1);
            if (!full_o) s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: the count never passes the depth, and a push while full stays full
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));
    p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> full_o);
    // R6: a pop on an empty stack changes nothing
    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !push_i) |=> empty_o);
    // R6: a push is read back on top in the next cycle
    p_push_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> (top_o == $past(data_i)));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_pkg::*;
#(
    parameter int PC_W      = 12,
    parameter int STK_DEPTH = 8,
    parameter int VEC_STEP  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic [NUM_SRC-1:0] irq_en_i,
    input  logic               gie_set_i,
    input  logic               gie_clr_i,
    input  logic               call_i,
    input  logic               ret_i,
    input  logic               reti_i,
    input  logic [PC_W-1:0]    pc_i,
    output logic               vec_load_o,
    output logic [PC_W-1:0]    vec_addr_o,
    output logic               stk_push_o,
    output logic               stk_pop_o,
    output logic [PC_W-1:0]    ret_addr_o,
    output logic               stk_full_o,
    output logic               gie_o
);
    localparam int IW = $clog2(NUM_SRC);

    typedef struct packed {
        logic boot;
        logic gie;
    } ctl_st_t;

    ctl_st_t s_d, s_q;

    logic [NUM_SRC-1:0] pend, cand, grant, clr;
    logic [IW-1:0]      win_idx;
    logic               win_any, ack, strobe_busy, pop_req, stk_empty, push_req;

    irq_pending #(.N(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(irq_req_i), .clr_i(clr), .pend_o(pend)
    );

    irq_arbiter #(.N(NUM_SRC)) u_arb (
        .cand_i(cand), .grant_o(grant), .idx_o(win_idx), .any_o(win_any)
    );

    ret_stack #(.PC_W(PC_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push_i(push_req), .pop_i(pop_req),
        .data_i(pc_i), .top_o(ret_addr_o), .full_o(stk_full_o), .empty_o(stk_empty)
    );

    always_comb begin
        cand        = pend & irq_en_i;
        strobe_busy = call_i | ret_i | reti_i;
        ack         = s_q.gie & win_any & ~stk_full_o & ~strobe_busy & ~s_q.boot;
        clr         = ack ? grant : '0;
        pop_req     = ret_i | reti_i;
        push_req    = ack | (call_i & ~pop_req);

        s_d      = s_q;
        s_d.boot = 1'b0;
        if (gie_set_i) s_d.gie = 1'b1;
        if (gie_clr_i) s_d.gie = 1'b0;
        if (reti_i)    s_d.gie = 1'b1;
        if (ack)       s_d.gie = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{boot: 1'b1, gie: 1'b0};
        else        s_q <= s_d;
    end

    assign vec_load_o = s_q.boot | ack;
    assign vec_addr_o = s_q.boot ? '0 : PC_W'(vector_of(int'(win_idx), VEC_STEP));
    assign stk_push_o = push_req;
    assign stk_pop_o  = pop_req & ~stk_empty;
    assign gie_o      = s_q.gie;

    // R1: the reset vector is presented once
    p_boot_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.boot |=> !s_q.boot);
    // R3: a full stack blocks every entry
    p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_full_o && !s_q.boot) |-> !vec_load_o);
    // R5: an entry drops the global enable
    p_entry_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_load_o && !s_q.boot) |=> !gie_o);
    // R5: an entry takes its pending flag away
    p_entry_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ((grant & irq_req_i) == '0)) |=> ((pend & $past(grant)) == '0));
    // R7: return from interrupt re-enables
    p_reti_gie_r7: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> gie_o);
    // R9: no push collides with a pop
    p_no_push_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop_o |-> !stk_push_o);
endmodule

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  req = '0, en = '0;
    logic        gset = 1'b0, gclr = 1'b0, call = 1'b0, ret = 1'b0, reti = 1'b0;
    logic [11:0] pc = '0;
    logic        vload, push, pop, full, gie;
    logic [11:0] vaddr, raddr;
    int          n_run = 0, n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irq_entry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(req), .irq_en_i(en),
        .gie_set_i(gset), .gie_clr_i(gclr), .call_i(call), .ret_i(ret), .reti_i(reti),
        .pc_i(pc), .vec_load_o(vload), .vec_addr_o(vaddr), .stk_push_o(push),
        .stk_pop_o(pop), .ret_addr_o(raddr), .stk_full_o(full), .gie_o(gie)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        req = '0; gset = 0; gclr = 0; call = 0; ret = 0; reti = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; idle(); en = '0;
        repeat (3) tick();
        rst_n = 1;
        #1;
        chk("R1 boot load", vload, 1); chk("R1 boot addr", vaddr, 12'h000);
        chk("R1 gie", gie, 0);         chk("R1 full", full, 0);
        tick(); #1;
        chk("R1 boot once", vload, 0);
    endtask

    task automatic t_vectors();
        gset = 1; en = 4'hF; tick(); gset = 0;
        for (int s = 0; s < 4; s++) begin
            req = 4'(1 << s); pc = 12'h300 + 12'(s); #1;
            chk("R5 no load in request cycle", vload, 0);
            tick(); req = '0; #1;
            chk("R5 load", vload, 1); chk("R2 vector", vaddr, 32'((s + 1) * 4));
            chk("R5 push", push, 1);
            tick(); #1;
            chk("R5 gie cleared", gie, 0); chk("R5 single load", vload, 0);
            reti = 1; #1;
            chk("R6 pop", pop, 1); chk("R6 ret addr", raddr, 12'h300 + 12'(s));
            tick(); reti = 0; #1;
            chk("R7 reti sets gie", gie, 1);
        end
    endtask

    task automatic t_priority();
        req = 4'b1110; tick(); req = '0; #1;
        chk("R4 first 008", vaddr, 12'h008); chk("R4 load", vload, 1);
        tick(); reti = 1; #1;
        chk("R9 none in reti cycle", vload, 0);
        tick(); reti = 0; #1;
        chk("R4 second 00C", vaddr, 12'h00C); chk("R4 load2", vload, 1);
        tick(); reti = 1; tick(); reti = 0; #1;
        chk("R4 third 010", vaddr, 12'h010); chk("R4 load3", vload, 1);
        tick(); reti = 1; tick(); reti = 0; #1;
        chk("R4 drained", vload, 0);
    endtask

    task automatic t_mask();
        en = '0; req = 4'b0001; tick(); req = '0;
        for (int k = 0; k < 3; k++) begin
            #1; chk("R3 source disabled", vload, 0); tick();
        end
        en = 4'b0001; #1;
        chk("R3 kept pending", vload, 1); chk("R3 addr", vaddr, 12'h004);
        tick(); ret = 1; #1;
        chk("R6 ret pops", pop, 1);
        tick(); ret = 0; #1;
        chk("R7 ret keeps gie off", gie, 0);
        en = 4'hF; req = 4'b0010; tick(); req = '0; #1;
        chk("R3 global off", vload, 0);
        tick(); gset = 1; #1;
        chk("R3 still off", vload, 0);
        tick(); gset = 0; #1;
        chk("R3 taken after set", vload, 1); chk("R3 addr 008", vaddr, 12'h008);
        tick(); reti = 1; tick(); reti = 0;
    endtask

    task automatic t_full();
        en = '0;
        for (int i = 0; i < 9; i++) begin
            call = 1; pc = 12'h100 + 12'(i); #1;
            chk("R6 call push", push, 1);
            tick();
        end
        call = 0; #1;
        chk("R8 full", full, 1);
        en = 4'b1000; req = 4'b1000; tick(); req = '0; #1;
        chk("R3 full blocks", vload, 0);
        tick(); #1;
        chk("R3 full blocks again", vload, 0);
        ret = 1; #1;
        chk("R6 pop newest", raddr, 12'h108); chk("R9 none in ret cycle", vload, 0);
        tick(); ret = 0; pc = 12'h200; #1;
        chk("R3 entry after slot frees", vload, 1); chk("R2 addr 010", vaddr, 12'h010);
        tick(); #1;
        chk("R8 full again", full, 1);
        reti = 1; #1;
        chk("R6 pop irq pc", raddr, 12'h200);
        tick(); reti = 0;
        for (int k = 7; k >= 1; k--) begin
            ret = 1; #1;
            chk("R8 pop", pop, 1); chk("R8 order", raddr, 12'h100 + 12'(k));
            tick();
        end
        #1; chk("R8 oldest lost, empty", pop, 0);
        tick(); ret = 0; en = '0;
    endtask

    task automatic t_strobe();
        gset = 1; gclr = 1; tick(); idle(); #1;
        chk("R10 clear wins", gie, 0);
        gset = 1; tick(); gset = 0; #1;
        chk("R10 set", gie, 1);
        gclr = 1; tick(); gclr = 0; #1;
        chk("R10 clear", gie, 0);
        call = 1; pc = 12'h050; tick();
        ret = 1; pc = 12'h060; #1;
        chk("R9 pop wins", pop, 1); chk("R9 no push", push, 0); chk("R9 addr", raddr, 12'h050);
        tick(); call = 0; #1;
        chk("R9 call dropped", pop, 0);
        tick(); ret = 0;
        gset = 1; tick(); gset = 0;
        en = 4'b0001; req = 4'b0001; tick(); req = '0;
        call = 1; pc = 12'h070; #1;
        chk("R9 none in call cycle", vload, 0); chk("R9 call push", push, 1);
        tick(); call = 0; pc = 12'h080; #1;
        chk("R9 taken after", vload, 1); chk("R9 addr 004", vaddr, 12'h004);
        tick(); reti = 1; #1;
        chk("R6 lifo 080", raddr, 12'h080);
        tick(); reti = 0; ret = 1; #1;
        chk("R6 lifo 070", raddr, 12'h070);
        tick(); ret = 0; en = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_vectors();
        t_priority();
        t_mask();
        t_full();
        t_strobe();
        finish_run();
    end

    initial begin
        #1000000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule